// File: doc/BRIEF.md
# Capacitive Touch Decision Logic

This block turns raw count samples from a capacitance scan engine into a clean ON/OFF touch status, one bit per sensor. Samples arrive one at a time on a shared bus with a valid strobe and a sensor index. For each sensor the block keeps a baseline and takes the difference between each new raw count and that baseline. A slow tracking rule lets the baseline follow drift. A finger threshold with a consecutive-sample count decides when a touch starts, and a hysteresis band decides when it ends.

Each sensor runs its own four-state machine. SEED waits for the first sample and loads the baseline from it. IDLE means untouched. ARMING counts over-threshold samples in a row. ON means touched. The transitions are:
- SEED→IDLE on any sample.
- IDLE→ARMING on an over-threshold sample, or IDLE→ON when the required count is one.
- ARMING→ON when the count reaches the configured number.
- ARMING→IDLE on a sample at or below the threshold.
- ON→IDLE when the difference drops under the release level.
- Any state→SEED when the sensor is disabled or a forced baseline reset is applied.

Top module: `cap_touch_judge`

## Requirements
- R1: While reset is applied and right after it, every status bit is 0 and every sensor is in SEED.
- R2: The first sample a sensor receives after reset, after being enabled, or after a forced baseline reset loads its baseline with the raw count and never sets its status.
- R3: The difference is the raw count minus the baseline. A negative result is treated as zero, so a raw count below the baseline never counts as a touch.
- R4: When the difference is at or below the noise threshold, the baseline moves one count toward the raw count. When the difference is above the noise threshold, the baseline does not change.
- R5: A sensor turns ON only after N consecutive samples whose difference is strictly greater than the finger threshold, where N is the debounce setting. A debounce setting of 0 behaves as 1. The status only rises on a cycle that carries a sample.
- R6: Before activation, any sample whose difference is at or below the finger threshold clears the consecutive count back to zero.
- R7: An ON sensor returns to OFF on a sample whose difference is below (finger threshold − hysteresis), saturated at zero. A difference at or above that level keeps it ON.
- R8: A finger threshold below 3 is treated as 3.
- R9: Status bit i is 1 exactly when sensor i is ON. A sensor whose enable bit is 0 reports 0, ignores samples and goes back to SEED.
- R10: A forced baseline reset pulse returns every sensor to SEED, so the status is all zero on the next cycle.
- R11: A sample only affects the sensor named by its index. The state of every other sensor is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | A raw count sample is present this cycle |
| sample_idx | input | IDX_W | Sensor the sample belongs to |
| sample_raw | input | CNT_W | Raw count value |
| sensor_en | input | N_SENSORS | Per-sensor enable mask |
| finger_th | input | TH_W | Finger threshold relative to the baseline |
| noise_th | input | TH_W | Noise threshold for baseline tracking |
| hyst | input | TH_W | Hysteresis subtracted from the finger threshold for release |
| debounce_n | input | DB_W | Consecutive over-threshold samples needed to activate |
| bl_reset | input | 1 | Forced baseline reset pulse |
| status | output | N_SENSORS | Per-sensor ON (1) / OFF (0) status |

## Verification
The bench feeds sample sequences chosen so that every expected status can be worked out from a known baseline:
- Runs of over-threshold samples, with and without a break, separate correct consecutive counting from counting that ignores breaks.
- Samples just above and just below the release level tell the hysteresis band apart from a plain threshold.
- Small offsets, followed by a difference exactly at the finger threshold, show whether the baseline stepped or stayed frozen.
- A raw count below the baseline, a threshold below the floor, and a zero debounce setting probe the clamping rules.
- Two-sensor sequences with enable changes and a forced reset show that sensors stay independent and are reseeded correctly.

// File: rtl/cap_touch_pkg.sv
package cap_touch_pkg;
    typedef enum logic [1:0] {
        ST_SEED   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ARMING = 2'd2,
        ST_ON     = 2'd3
    } sense_state_t;

    localparam int unsigned FINGER_FLOOR = 3;
endpackage

// File: rtl/cap_diff_calc.sv
module cap_diff_calc #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned TH_W  = 8
) (
    input  logic [CNT_W-1:0] raw,
    input  logic [CNT_W-1:0] base,
    input  logic [TH_W-1:0]  finger_th,
    input  logic [TH_W-1:0]  noise_th,
    input  logic [TH_W-1:0]  hyst,
    output logic             over_finger,
    output logic             over_noise,
    output logic             under_release,
    output logic             raw_above,
    output logic             raw_below
);
    import cap_touch_pkg::*;

    logic [CNT_W:0]   wide_diff;
    logic [CNT_W-1:0] diff;
    logic [TH_W-1:0]  eff_finger;
    logic [TH_W-1:0]  release_lvl;

    always_comb begin
        // Signed difference with one guard bit; negative clamps to zero.
        wide_diff = {1'b0, raw} - {1'b0, base};
        diff      = wide_diff[CNT_W] ? '0 : wide_diff[CNT_W-1:0];

        // Finger threshold never drops below the floor.
        eff_finger = (finger_th < TH_W'(FINGER_FLOOR)) ? TH_W'(FINGER_FLOOR) : finger_th;

        // Release level saturates at zero.
        release_lvl = (eff_finger > hyst) ? (eff_finger - hyst) : '0;

        over_finger   = diff > CNT_W'(eff_finger);
        over_noise    = diff > CNT_W'(noise_th);
        under_release = diff < CNT_W'(release_lvl);
        raw_above     = raw > base;
        raw_below     = raw < base;
    end
endmodule

// File: rtl/cap_sensor_fsm.sv
module cap_sensor_fsm #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DB_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             force_seed,
    input  logic             smp_valid,
    input  logic [CNT_W-1:0] smp_raw,
    input  logic [DB_W-1:0]  debounce_n,
    input  logic             over_finger,
    input  logic             over_noise,
    input  logic             under_release,
    input  logic             raw_above,
    input  logic             raw_below,
    output logic [CNT_W-1:0] base,
    output logic             is_on
);
    import cap_touch_pkg::*;

    sense_state_t     state_q, state_d;
    logic [CNT_W-1:0] base_q, base_d;
    logic [DB_W-1:0]  cnt_q, cnt_d;
    logic [DB_W-1:0]  need;
    logic [DB_W-1:0]  cnt_inc;

    always_comb begin
        need    = (debounce_n == '0) ? DB_W'(1) : debounce_n;
        cnt_inc = cnt_q + DB_W'(1);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        if (!enable || force_seed) begin
            state_d = ST_SEED;
            cnt_d   = '0;
        end else if (smp_valid) begin
            unique case (state_q)
                ST_SEED: begin
                    base_d  = smp_raw;
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
                ST_IDLE: begin
                    if (over_finger) begin
                        if (need == DB_W'(1)) begin
                            state_d = ST_ON;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_ARMING;
                            cnt_d   = DB_W'(1);
                        end
                    end
                end
                ST_ARMING: begin
                    if (over_finger) begin
                        if (cnt_inc >= need) begin
                            state_d = ST_ON;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end else begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end
                end
                ST_ON: begin
                    if (under_release) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_SEED;
            endcase
            // Baseline tracking for quiet samples.
            if (state_q != ST_SEED && !over_noise) begin
                if (raw_above) begin
                    base_d = base_q + CNT_W'(1);
                end else if (raw_below) begin
                    base_d = base_q - CNT_W'(1);
                end
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEED;
            base_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        base  = base_q;
        is_on = (state_q == ST_ON) && enable;
    end
endmodule

// File: rtl/cap_touch_judge.sv
module cap_touch_judge #(
    parameter int unsigned N_SENSORS = 2,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned TH_W      = 8,
    parameter int unsigned DB_W      = 4,
    localparam int unsigned IDX_W    = (N_SENSORS > 1) ? $clog2(N_SENSORS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_valid,
    input  logic [IDX_W-1:0]     sample_idx,
    input  logic [CNT_W-1:0]     sample_raw,
    input  logic [N_SENSORS-1:0] sensor_en,
    input  logic [TH_W-1:0]      finger_th,
    input  logic [TH_W-1:0]      noise_th,
    input  logic [TH_W-1:0]      hyst,
    input  logic [DB_W-1:0]      debounce_n,
    input  logic                 bl_reset,
    output logic [N_SENSORS-1:0] status
);
    for (genvar gi = 0; gi < N_SENSORS; gi++) begin : g_sensor
        logic             hit;
        logic [CNT_W-1:0] base;
        logic             over_finger, over_noise, under_release;
        logic             raw_above, raw_below;

        assign hit = sample_valid && (sample_idx == IDX_W'(gi));

        cap_diff_calc #(.CNT_W(CNT_W), .TH_W(TH_W)) u_diff (
            .raw           (sample_raw),
            .base          (base),
            .finger_th     (finger_th),
            .noise_th      (noise_th),
            .hyst          (hyst),
            .over_finger   (over_finger),
            .over_noise    (over_noise),
            .under_release (under_release),
            .raw_above     (raw_above),
            .raw_below     (raw_below)
        );

        cap_sensor_fsm #(.CNT_W(CNT_W), .DB_W(DB_W)) u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .enable        (sensor_en[gi]),
            .force_seed    (bl_reset),
            .smp_valid     (hit),
            .smp_raw       (sample_raw),
            .debounce_n    (debounce_n),
            .over_finger   (over_finger),
            .over_noise    (over_noise),
            .under_release (under_release),
            .raw_above     (raw_above),
            .raw_below     (raw_below),
            .base          (base),
            .is_on         (status[gi])
        );
    end
endmodule

// File: rtl/cap_touch_judge_chk.sv
module cap_touch_judge_chk #(
    parameter int unsigned N_SENSORS = 2,
    parameter int unsigned IDX_W     = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_valid,
    input logic [IDX_W-1:0]     sample_idx,
    input logic [N_SENSORS-1:0] sensor_en,
    input logic                 bl_reset,
    input logic [N_SENSORS-1:0] status
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == '0));

    assert_rise_needs_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ((status & ~$past(status)) == '0));

    assert_reset_blanks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bl_reset |=> (status == '0));

    for (genvar gi = 0; gi < N_SENSORS; gi++) begin : g_chk
        assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !sensor_en[gi] |=> !status[gi]);

        assert_other_untouched_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_valid && sample_idx != IDX_W'(gi) && !bl_reset && sensor_en[gi])
            |=> ((status[gi] == $past(status[gi])) || !sensor_en[gi]));
    end
endmodule

bind cap_touch_judge cap_touch_judge_chk #(.N_SENSORS(N_SENSORS), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_idx   (sample_idx),
    .sensor_en    (sensor_en),
    .bl_reset     (bl_reset),
    .status       (status)
);

// File: tb/sim_cap_touch_judge.sv
`timescale 1ns/1ps
module sim_cap_touch_judge;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [0:0]  sample_idx = '0;
    logic [15:0] sample_raw = '0;
    logic [1:0]  sensor_en = 2'b11;
    logic [7:0]  finger_th = 8'd50;
    logic [7:0]  noise_th = 8'd20;
    logic [7:0]  hyst = 8'd10;
    logic [3:0]  debounce_n = 4'd3;
    logic        bl_reset = 1'b0;
    logic [1:0]  status;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cap_touch_judge #(.N_SENSORS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_idx(sample_idx), .sample_raw(sample_raw),
        .sensor_en(sensor_en), .finger_th(finger_th), .noise_th(noise_th),
        .hyst(hyst), .debounce_n(debounce_n), .bl_reset(bl_reset),
        .status(status)
    );

    task automatic chk(input string req, input logic [1:0] exp);
        n_checks++;
        if (status !== exp) begin
            n_fail++;
            $display("FAIL %s: status actual=%b expected=%b", req, status, exp);
        end
    endtask

    task automatic smp(input int idx, input int raw);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_idx   = 1'(idx);
        sample_raw   = 16'(raw);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 during reset", 2'b00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 2'b00);
    endtask

    task automatic t_seed_and_debounce();
        smp(0, 1000); chk("R2 seed", 2'b00);
        smp(0, 1100); smp(0, 1100); chk("R5 two of three", 2'b00);
        smp(0, 1100); chk("R5 third sample", 2'b01);
    endtask

    task automatic t_debounce_clear();
        smp(0, 1000); chk("R7 release at zero diff", 2'b00);
        smp(0, 1100); smp(0, 1100); smp(0, 1040);
        smp(0, 1100); smp(0, 1100); chk("R6 count cleared", 2'b00);
        smp(0, 1100); chk("R6 fresh run completes", 2'b01);
    endtask

    task automatic t_hysteresis();
        smp(0, 1045); chk("R7 inside band", 2'b01);
        smp(0, 1040); chk("R7 at release level", 2'b01);
        smp(0, 1039); chk("R7 below release level", 2'b00);
    endtask

    task automatic t_tracking();
        debounce_n = 4'd1;
        smp(0, 1010);   // baseline 1000 -> 1001
        smp(0, 1051); chk("R4 baseline stepped, diff equals threshold", 2'b00);
        smp(0, 1052); chk("R5 diff above threshold", 2'b01);
        smp(0, 1001); chk("R7 release", 2'b00);
        smp(0, 1022);   // diff 21 above noise: frozen
        smp(0, 1052); chk("R4 baseline frozen", 2'b01);
        smp(0, 1001); chk("R7 release again", 2'b00);
    endtask

    task automatic t_clamp();
        smp(0, 900); chk("R3 negative diff clamped", 2'b00);
        smp(0, 1051); chk("R3 baseline stepped down", 2'b01);
        smp(0, 1000); chk("R7 release", 2'b00);
    endtask

    task automatic t_db_zero_and_floor();
        debounce_n = 4'd0;
        smp(0, 1060); chk("R5 debounce zero acts as one", 2'b01);
        smp(0, 1000); chk("R7 release", 2'b00);
        debounce_n = 4'd1; finger_th = 8'd1; hyst = 8'd0;
        smp(0, 1003); chk("R8 floor not exceeded", 2'b00);   // baseline -> 1001
        smp(0, 1005); chk("R8 above floor", 2'b01);
        smp(0, 1001); chk("R8 release", 2'b00);
        finger_th = 8'd50; hyst = 8'd10;
    endtask

    task automatic t_second_and_enable();
        smp(1, 500); chk("R2 seed sensor 1", 2'b00);
        smp(1, 600); chk("R11 only sensor 1 on", 2'b10);
        @(negedge clk); sensor_en = 2'b01; #1;
        chk("R9 disabled reports off", 2'b00);
        smp(1, 600); chk("R9 disabled ignores sample", 2'b00);
        @(negedge clk); sensor_en = 2'b11; #1;
        chk("R9 re-enabled starts off", 2'b00);
        smp(1, 600); chk("R2 reseed after enable", 2'b00);
        smp(1, 700); chk("R9 active after reseed", 2'b10);
    endtask

    task automatic t_forced_reset();
        @(negedge clk); bl_reset = 1'b1;
        @(negedge clk); bl_reset = 1'b0;
        chk("R10 status cleared", 2'b00);
        smp(0, 1200); chk("R10 reseed", 2'b00);
        smp(0, 1240); chk("R10 new baseline used", 2'b00);
        smp(0, 1260); chk("R10 active on new baseline", 2'b01);
        smp(1, 700); chk("R11 sensor 1 seeds, sensor 0 kept", 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_seed_and_debounce();
        t_debounce_clear();
        t_hysteresis();
        t_tracking();
        t_clamp();
        t_db_zero_and_floor();
        t_second_and_enable();
        t_forced_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule